// File: doc/BRIEF.md
# All-Pairs Index Sequencer

This block issues the index stream for an all-pairs interaction sweep over a set of 2^IDX_W items (256 by default). A start pulse launches a two-level nested loop that visits every (target, source) combination, at most one combination per clock. When the last combination has been issued, a single-level loop follows at once. It visits each item one time so that downstream logic can apply or write back the sums it has accumulated.

The indices leave the block as a stream. `valid` qualifies each beat. The `enable` input works as the downstream ready and provides back-pressure. While `enable` is low, `valid` is low and both indices hold. When `enable` returns high, the same beat is offered again. A beat counts as issued on any clock edge where `valid` is high, and `valid` is high exactly when the sweep is active and `enable` is high.

Side markers flag the first and last source of each target and the self-combination where the two indices match. A one-cycle `done` pulse marks the end of the sweep.

Top module: `pair_seq_top`

## Requirements
- R1: A synchronous reset returns the block to idle: both indices 0, and `valid`, `phase`, `done` and all markers low.
- R2: In idle, a high `start` at a clock edge begins the pair sweep with both indices at 0. A `start` seen while the sweep is active or finishing is ignored.
- R3: In the pair sweep (`phase` = 0), each issued beat advances `inner_idx` by one. When `inner_idx` wraps from 255 to 0, `outer_idx` advances by one. The first beat is (0,0).
- R4: After the beat with `outer_idx` = 255 and `inner_idx` = 255, the block enters the single sweep (`phase` = 1). In this sweep `outer_idx` stays 0 and `inner_idx` runs from 0 to 255, one step per issued beat.
- R5: `done` is high for exactly one cycle, the cycle after the beat with `inner_idx` = 255 of the single sweep. The block is idle in the cycle after that.
- R6: While `enable` is low, `valid` is low and both indices and the phase hold. In idle, `valid` is low regardless of `enable`.
- R7: `first_inner` is high exactly on issued beats with `inner_idx` = 0. `last_inner` is high exactly on issued beats with `inner_idx` = 255. Both apply in either phase.
- R8: `skip_self` is high exactly on issued pair-sweep beats where `inner_idx` equals `outer_idx`. It is never high in the single sweep.
- R9: A reset asserted in the middle of a sweep ends it. The block is idle with both indices 0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Launches a sweep when idle |
| enable | input | 1 | Downstream ready; low stalls the stream |
| outer_idx | output | IDX_W | Target index (0 in the single sweep) |
| inner_idx | output | IDX_W | Source index, or the item index in the single sweep |
| phase | output | 1 | 0 = pair sweep, 1 = single sweep |
| valid | output | 1 | Beat is issued this cycle |
| first_inner | output | 1 | Issued beat has inner index 0 |
| last_inner | output | 1 | Issued beat has inner index at maximum |
| skip_self | output | 1 | Issued pair beat with equal indices |
| done | output | 1 | One-cycle end-of-sweep pulse |

## Verification
A `start` sampled at an edge shows up as the first beat (0,0) in the cycle right after that edge. The indices, `valid` and the markers then follow the registered state in the same cycle as the `enable` value that gates them. The last single-sweep beat is followed by `done` one cycle later and by idle one cycle after that. The bench drives inputs just after the falling edge and samples 1 ns later. It advances a behavioural model at each rising edge and compares every output against that model on every cycle. Stall patterns are included, so back-pressure is checked on exactly the cycles it applies to.

// File: rtl/pair_seq_pkg.sv
package pair_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_PAIR   = 2'd1,
    ST_SINGLE = 2'd2,
    ST_FINISH = 2'd3
  } seq_state_t;
endpackage

// File: rtl/pair_seq_wrap_ctr.sv
module pair_seq_wrap_ctr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] val,
  output logic         at_max
);
  always_ff @(posedge clk) begin
    if (rst || clr)  val <= '0;
    else if (inc)    val <= val + 1'b1;
  end

  assign at_max = &val;
endmodule

// File: rtl/pair_seq_ctrl.sv
module pair_seq_ctrl
  import pair_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       enable,
  input  logic       inner_max,
  input  logic       outer_max,
  output seq_state_t state,
  output logic       issue,
  output logic       outer_step,
  output logic       launch
);
  seq_state_t state_nx;

  assign issue      = enable && (state == ST_PAIR || state == ST_SINGLE);
  assign outer_step = issue && (state == ST_PAIR) && inner_max;
  assign launch     = (state == ST_IDLE) && start;

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE:   if (start) state_nx = ST_PAIR;
      ST_PAIR:   if (outer_step && outer_max) state_nx = ST_SINGLE;
      ST_SINGLE: if (issue && inner_max) state_nx = ST_FINISH;
      ST_FINISH: state_nx = ST_IDLE;
      default:   state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= state_nx;
  end
endmodule

// File: rtl/pair_seq_top.sv
module pair_seq_top
  import pair_seq_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             enable,
  output logic [IDX_W-1:0] outer_idx,
  output logic [IDX_W-1:0] inner_idx,
  output logic             phase,
  output logic             valid,
  output logic             first_inner,
  output logic             last_inner,
  output logic             skip_self,
  output logic             done
);
  seq_state_t state;
  logic issue, outer_step, launch, inner_max, outer_max;

  pair_seq_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .enable     (enable),
    .inner_max  (inner_max),
    .outer_max  (outer_max),
    .state      (state),
    .issue      (issue),
    .outer_step (outer_step),
    .launch     (launch)
  );

  // inner counter steps on every issued beat; outer on inner wrap in pair sweep
  pair_seq_wrap_ctr #(.W(IDX_W)) u_inner (
    .clk    (clk),
    .rst    (rst),
    .clr    (launch),
    .inc    (issue),
    .val    (inner_idx),
    .at_max (inner_max)
  );

  pair_seq_wrap_ctr #(.W(IDX_W)) u_outer (
    .clk    (clk),
    .rst    (rst),
    .clr    (launch),
    .inc    (outer_step),
    .val    (outer_idx),
    .at_max (outer_max)
  );

  assign valid       = issue;
  assign phase       = (state == ST_SINGLE);
  assign first_inner = issue && (inner_idx == '0);
  assign last_inner  = issue && inner_max;
  assign skip_self   = issue && (state == ST_PAIR) && (inner_idx == outer_idx);
  assign done        = (state == ST_FINISH);
endmodule

// File: rtl/pair_seq_chk.sv
module pair_seq_chk #(
  parameter int IDX_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             enable,
  input logic [IDX_W-1:0] outer_idx,
  input logic [IDX_W-1:0] inner_idx,
  input logic             phase,
  input logic             valid,
  input logic             first_inner,
  input logic             last_inner,
  input logic             skip_self,
  input logic             done
);
  localparam logic [IDX_W-1:0] TOP = '1;

  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (!valid && !done && !phase && outer_idx == '0 && inner_idx == '0));

  p_inner_step_r3: assert property (@(posedge clk) disable iff (rst)
    (valid && !phase && !last_inner) |=>
      (inner_idx == $past(inner_idx) + 1'b1 && outer_idx == $past(outer_idx)));

  p_outer_step_r3: assert property (@(posedge clk) disable iff (rst)
    (valid && !phase && last_inner && outer_idx != TOP) |=>
      (inner_idx == '0 && outer_idx == $past(outer_idx) + 1'b1));

  p_into_single_r4: assert property (@(posedge clk) disable iff (rst)
    (valid && !phase && last_inner && outer_idx == TOP) |=>
      (phase && inner_idx == '0 && outer_idx == '0));

  p_done_single_r5: assert property (@(posedge clk) disable iff (rst)
    done |=> (!done && !valid && !phase));

  p_stall_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !enable |=> ($stable(inner_idx) && $stable(outer_idx)));

  p_stall_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    !enable |-> !valid);

  p_first_mark_r7: assert property (@(posedge clk) disable iff (rst)
    first_inner |-> (valid && inner_idx == '0));

  p_last_mark_r7: assert property (@(posedge clk) disable iff (rst)
    last_inner |-> (valid && inner_idx == TOP));

  p_self_skip_r8: assert property (@(posedge clk) disable iff (rst)
    skip_self |-> (valid && !phase && inner_idx == outer_idx));
endmodule

bind pair_seq_top pair_seq_chk #(.IDX_W(IDX_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .enable      (enable),
  .outer_idx   (outer_idx),
  .inner_idx   (inner_idx),
  .phase       (phase),
  .valid       (valid),
  .first_inner (first_inner),
  .last_inner  (last_inner),
  .skip_self   (skip_self),
  .done        (done)
);

// File: tb/tb_pair_seq_top.sv
`timescale 1ns/1ps
module tb_pair_seq_top;
  localparam int W   = 8;
  localparam int TOP = (1 << W) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic enable = 1'b0;
  logic [W-1:0] outer_idx, inner_idx;
  logic phase, valid, first_inner, last_inner, skip_self, done;

  always #2.5 clk = ~clk;

  pair_seq_top #(.IDX_W(W)) dut (
    .clk(clk), .rst(rst), .start(start), .enable(enable),
    .outer_idx(outer_idx), .inner_idx(inner_idx), .phase(phase),
    .valid(valid), .first_inner(first_inner), .last_inner(last_inner),
    .skip_self(skip_self), .done(done)
  );

  // behavioural model: 0 idle, 1 pair sweep, 2 single sweep, 3 finishing
  int ms = 0, mo = 0, mi = 0;
  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit seen_done = 0;

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      ms = 0; mo = 0; mi = 0;
    end else begin
      case (ms)
        0: if (start) begin ms = 1; mo = 0; mi = 0; end
        1: if (enable) begin
             if (mi == TOP) begin
               mi = 0;
               if (mo == TOP) begin mo = 0; ms = 2; end
               else mo = mo + 1;
             end else mi = mi + 1;
           end
        2: if (enable) begin
             if (mi == TOP) begin mi = 0; ms = 3; end
             else mi = mi + 1;
           end
        default: ms = 0;
      endcase
    end
  end

  task automatic chk1(string tag, string what, int act, int exp);
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  // compare every output against the model; ctx names the scenario requirement
  task automatic compare(string ctx);
    bit ev;
    ev = (ms == 1 || ms == 2) && enable;
    n_cmp++;
    chk1({ctx, "/R3"}, "outer_idx", int'(outer_idx), mo);
    chk1({ctx, "/R3"}, "inner_idx", int'(inner_idx), mi);
    chk1({ctx, "/R4"}, "phase", int'(phase), int'(ms == 2));
    chk1({ctx, "/R6"}, "valid", int'(valid), int'(ev));
    chk1({ctx, "/R7"}, "first_inner", int'(first_inner), int'(ev && mi == 0));
    chk1({ctx, "/R7"}, "last_inner", int'(last_inner), int'(ev && mi == TOP));
    chk1({ctx, "/R8"}, "skip_self", int'(skip_self), int'(ev && ms == 1 && mi == mo));
    chk1({ctx, "/R5"}, "done", int'(done), int'(ms == 3));
  endtask

  task automatic step(bit r, bit s, bit e, string ctx);
    @(negedge clk);
    rst = r; start = s; enable = e;
    #1;
    compare(ctx);
  endtask

  // watchdog
  initial begin
    wait (cyc > 200000);
    n_bad++;
    $display("FAIL watchdog: actual %0d cycles expected under 200000", cyc);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    // R1: reset state
    for (int k = 0; k < 3; k++) step(1, 0, 1, "R1");
    // R6: idle, enable high, no start: nothing issued
    for (int k = 0; k < 4; k++) step(0, 0, 1, "R6");
    // R2: launch, full sweep with periodic stalls and a stray start mid-run
    step(0, 1, 1, "R2");
    for (int k = 0; k < 90000; k++) begin
      bit e, s;
      e = (k % 7) != 3;
      s = (k == 300) || (k == 65700);
      step(0, s, e, s ? "R2" : "R3");
      if (done) seen_done = 1;
      if (seen_done && ms == 0) break;
    end
    chk1("R5", "done pulse seen", int'(seen_done), 1);
    n_cmp++;
    for (int k = 0; k < 3; k++) step(0, 0, 1, "R5");
    // R9: reset in the middle of a sweep
    step(0, 1, 1, "R2");
    for (int k = 0; k < 700; k++) step(0, 0, 1, "R3");
    step(1, 0, 1, "R9");
    step(0, 0, 1, "R9");
    chk1("R9", "outer after reset", int'(outer_idx), 0);
    chk1("R9", "inner after reset", int'(inner_idx), 0);
    n_cmp++;
    // R6: launch then hold enable low, indices stay at (0,0)
    step(0, 1, 0, "R6");
    for (int k = 0; k < 6; k++) step(0, 0, 0, "R6");
    for (int k = 0; k < 20; k++) step(0, 0, (k % 2) == 0, "R6");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule